// File: doc/BRIEF.md
# Quaternary Fat-Tree Packet Router

This block is one router node of a tree-shaped on-die packet network that links pre-built functional tiles. It has four downward child ports and one upward parent port. Every link carries a 64-bit single-word packet in parallel, with a valid/ready handshake. The router reads a hierarchical leaf address from the top bits of each packet. It sends the packet down to one child when the destination lies inside the router's own subtree, and up to the parent otherwise. Interior routers only forward packets; leaves are the only legal destinations.

Parameters set the tree depth, the router's level and its subtree identifier. Each output owns a round-robin arbiter and a single output register. A packet therefore crosses the router in exactly one clock cycle when nothing stalls it. An input keeps its packet until the router takes it, so packets are neither lost nor repeated. A packet that would have to leave through the port it entered on is consumed without being forwarded, and an error pulse reports it.

Top module: `fatq_router`

## Requirements
- R1: Ports 0 to 3 are children and port 4 is the parent. The address is the top 2*NUM_LEVELS bits of the packet, read as 2-bit digits with the most significant first. With the defaults (3 levels, level 1, subtree id 2), a packet whose bits [63:62] equal 2 goes to the child numbered by bits [61:60]; any other packet goes to port 4.
- R2: A packet accepted at a clock edge (in_valid and in_ready both high) is presented on its output port, valid and unchanged, right after that same edge.
- R3: While out_valid is high and out_ready is low on a port, the port keeps out_valid high and its data stable. No other packet is accepted for that port.
- R4: At most one packet is accepted for any output in a cycle. in_ready is never high while in_valid is low.
- R5: When several inputs contend for one output, the grants rotate round-robin. The input after the last one granted has the highest priority.
- R6: Every accepted, validly addressed packet is delivered exactly once, on its routed port.
- R7: Two cases are protocol errors: a parent packet whose address lies outside the subtree, and a child packet whose address lies under that same child. The router consumes such a packet, forwards it nowhere, and raises err_o for one cycle after the edge that accepts it.
- R8: Reset clears all output valids and err_o, and sets every arbiter's priority to start at port 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 5 | Per-input packet valid |
| in_data_i | input | 5x64 | Per-input packet word |
| in_ready_o | output | 5 | Per-input acceptance |
| out_valid_o | output | 5 | Per-output packet valid |
| out_data_o | output | 5x64 | Per-output registered packet word |
| out_ready_i | input | 5 | Per-output downstream ready |
| err_o | output | 1 | Protocol error pulse |

## Verification
The assertions check, on every cycle, the properties that hold at each single step:
- a stalled output holds its word;
- each output grants at most one input;
- no input is granted its own port;
- in_ready never rises without in_valid;
- a new output word and err_o each follow an accepted handshake.

The bench scenarios show the properties that span a sequence of cycles. These are the address decode to the right port, the exact one-cycle hop, the order of grants under three-way contention after reset, and that no packet is lost or duplicated across long random runs with random backpressure.

// File: rtl/fatq_pkg.sv
package fatq_pkg;
  localparam int NP     = 5;
  localparam int PARENT = 4;
endpackage

// File: rtl/fatq_route.sv
module fatq_route import fatq_pkg::*; #(
  parameter int DW         = 64,
  parameter int NUM_LEVELS = 3,
  parameter int LEVEL      = 1,
  parameter int SUBTREE_ID = 2,
  parameter int PORT       = 0
) (
  input  logic          valid_i,
  input  logic [DW-1:0] data_i,
  output logic [NP-1:0] req_o,
  output logic          bad_o
);
  localparam int AW  = 2 * NUM_LEVELS;
  localparam int PSH = AW - 2 * LEVEL;
  localparam int DSH = AW - 2 - 2 * LEVEL;
  localparam logic [AW-1:0] SID = AW'(SUBTREE_ID);

  logic [AW-1:0] addr, prefix;
  logic [1:0]    digit;
  logic          in_sub;

  assign addr   = data_i[DW-1 -: AW];
  assign prefix = addr >> PSH;
  assign digit  = 2'(addr >> DSH);
  assign in_sub = (prefix == SID);

  always_comb begin
    bad_o = valid_i && (in_sub ? (int'(digit) == PORT) : (PORT == PARENT));
    req_o = '0;
    if (valid_i && !bad_o) begin
      if (in_sub) req_o[digit]  = 1'b1;
      else        req_o[PARENT] = 1'b1;
    end
  end
endmodule

// File: rtl/fatq_rr_arb.sv
module fatq_rr_arb #(
  parameter int N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  input  logic         adv_i,
  output logic [N-1:0] gnt_o
);
  localparam int W = $clog2(N);

  logic [W-1:0] ptr_q, win;

  // lowest rotated offset from the pointer wins
  always_comb begin
    win   = ptr_q;
    gnt_o = '0;
    for (int k = N - 1; k >= 0; k--) begin
      int idx;
      idx = (int'(ptr_q) + k) % N;
      if (req_i[idx]) win = W'(idx);
    end
    if (|req_i) gnt_o[win] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              ptr_q <= '0;
    else if (adv_i && |req_i) ptr_q <= (int'(win) == N - 1) ? '0 : win + 1'b1;
  end
endmodule

// File: rtl/fatq_router.sv
module fatq_router import fatq_pkg::*; #(
  parameter int DW         = 64,
  parameter int NUM_LEVELS = 3,
  parameter int LEVEL      = 1,
  parameter int SUBTREE_ID = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NP-1:0]          in_valid_i,
  input  logic [NP-1:0][DW-1:0]  in_data_i,
  output logic [NP-1:0]          in_ready_o,
  output logic [NP-1:0]          out_valid_o,
  output logic [NP-1:0][DW-1:0]  out_data_o,
  input  logic [NP-1:0]          out_ready_i,
  output logic                   err_o
);
  logic [NP-1:0][NP-1:0] req;      // [in][out]
  logic [NP-1:0][NP-1:0] req_col;  // [out][in]
  logic [NP-1:0][NP-1:0] gnt;      // [out][in]
  logic [NP-1:0]         bad, free;
  logic [NP-1:0][DW-1:0] nxt;

  for (genvar i = 0; i < NP; i++) begin : g_in
    fatq_route #(
      .DW(DW), .NUM_LEVELS(NUM_LEVELS), .LEVEL(LEVEL),
      .SUBTREE_ID(SUBTREE_ID), .PORT(i)
    ) u_rt (
      .valid_i(in_valid_i[i]),
      .data_i (in_data_i[i]),
      .req_o  (req[i]),
      .bad_o  (bad[i])
    );
  end

  for (genvar o = 0; o < NP; o++) begin : g_out
    for (genvar i = 0; i < NP; i++) begin : g_col
      assign req_col[o][i] = req[i][o];
    end
    assign free[o] = !out_valid_o[o] || out_ready_i[o];
    fatq_rr_arb #(.N(NP)) u_arb (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .req_i (req_col[o]),
      .adv_i (free[o]),
      .gnt_o (gnt[o])
    );
  end

  always_comb begin
    for (int o = 0; o < NP; o++) begin
      nxt[o] = '0;
      for (int i = 0; i < NP; i++)
        if (gnt[o][i]) nxt[o] = nxt[o] | in_data_i[i];
    end
  end

  always_comb begin
    for (int i = 0; i < NP; i++) begin
      in_ready_o[i] = bad[i];
      for (int o = 0; o < NP; o++)
        in_ready_o[i] = in_ready_o[i] | (gnt[o][i] & free[o]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= '0;
      out_data_o  <= '0;
      err_o       <= 1'b0;
    end else begin
      err_o <= |bad;
      for (int o = 0; o < NP; o++) begin
        if (free[o]) begin
          out_valid_o[o] <= |gnt[o];
          out_data_o[o]  <= nxt[o];
        end
      end
    end
  end
endmodule

// File: rtl/fatq_router_chk.sv
module fatq_router_chk import fatq_pkg::*; #(
  parameter int DW = 64
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [NP-1:0]         in_valid_i,
  input logic [NP-1:0]         in_ready_o,
  input logic [NP-1:0]         out_valid_o,
  input logic [NP-1:0][DW-1:0] out_data_o,
  input logic [NP-1:0]         out_ready_i,
  input logic                  err_o,
  input logic [NP-1:0][NP-1:0] gnt
);
  for (genvar o = 0; o < NP; o++) begin : g_p
    a_r3_hold_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_valid_o[o] && !out_ready_i[o] |=> out_valid_o[o] && $stable(out_data_o[o]));
    a_r4_one_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(gnt[o]));
    a_r7_no_uturn: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !gnt[o][o]);
    a_r2_from_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_valid_o[o] && !$past(out_valid_o[o] && !out_ready_i[o])
        |-> $past(in_valid_i & in_ready_o) != '0);
  end

  a_r4_ready_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_ready_o & ~in_valid_i) == '0);
  a_r7_err_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(in_valid_i & in_ready_o) != '0);
endmodule

bind fatq_router fatq_router_chk #(.DW(DW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_valid_i (in_valid_i),
  .in_ready_o (in_ready_o),
  .out_valid_o(out_valid_o),
  .out_data_o (out_data_o),
  .out_ready_i(out_ready_i),
  .err_o      (err_o),
  .gnt        (gnt)
);

// File: tb/sim_fatq_router.sv
module sim_fatq_router;
  import fatq_pkg::*;
  localparam int DW = 64;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk = ~clk;

  logic [NP-1:0]         bvalid, in_ready, out_valid, bready;
  logic [NP-1:0][DW-1:0] bdata, out_data;
  logic                  err;

  fatq_router #(.DW(DW), .NUM_LEVELS(3), .LEVEL(1), .SUBTREE_ID(2)) u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .in_valid_i(bvalid), .in_data_i(bdata), .in_ready_o(in_ready),
    .out_valid_o(out_valid), .out_data_o(out_data), .out_ready_i(bready),
    .err_o(err)
  );

  int checks = 0, errors = 0, serial = 0;
  logic [DW-1:0] expq [NP][64];
  int            expn [NP];
  logic [NP-1:0] acc_m, del_m, rdy_s, val_s;

  function automatic int route_of(logic [63:0] d, int src);
    if (d[63:62] == 2'd2) begin
      if (int'(d[61:60]) == src) return -1;
      return int'(d[61:60]);
    end
    if (src == PARENT) return -1;
    return PARENT;
  endfunction

  function automatic logic [63:0] mk(int src, logic [1:0] pre, logic [1:0] dig, int sn);
    return {pre, dig, 2'($urandom), 22'($urandom), 4'(src), 32'(sn)};
  endfunction

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic send(int src, logic [1:0] pre, logic [1:0] dig);
    serial++;
    bdata[src]  = mk(src, pre, dig, serial);
    bvalid[src] = 1'b1;
  endtask

  // called just after a falling edge; returns just after the next falling edge
  task automatic step();
    logic [NP-1:0][DW-1:0] dsnap, isnap;
    int cnt [NP];
    #4;
    val_s = bvalid; rdy_s = in_ready;
    acc_m = bvalid & in_ready;
    del_m = out_valid & bready;
    dsnap = out_data; isnap = bdata;
    @(posedge clk);
    @(negedge clk);
    for (int o = 0; o < NP; o++) begin
      cnt[o] = 0;
      if (del_m[o]) begin
        int f;
        f = -1;
        for (int k = 0; k < expn[o]; k++)
          if (f < 0 && expq[o][k] == dsnap[o]) f = k;
        check(f >= 0, "R6 delivered packet expected", dsnap[o], '0);
        if (f >= 0) begin
          for (int k = f; k < expn[o] - 1; k++) expq[o][k] = expq[o][k+1];
          expn[o]--;
        end
      end
    end
    for (int i = 0; i < NP; i++) begin
      if (acc_m[i]) begin
        int r;
        r = route_of(isnap[i], i);
        if (r >= 0) begin
          expq[r][expn[r]] = isnap[i];
          expn[r]++;
          cnt[r]++;
        end
        bvalid[i] = 1'b0;
      end
    end
    for (int o = 0; o < NP; o++)
      if (cnt[o] > 1) check(0, "R4 one accept per output", 64'(cnt[o]), 64'd1);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    bvalid = '0;
    bready = '1;
    for (int o = 0; o < NP; o++) expn[o] = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1357));
    bdata = '0;
    do_reset();

    // R8 reset state
    check(out_valid == '0, "R8 out_valid after reset", 64'(out_valid), 0);
    check(err == 1'b0, "R8 err after reset", 64'(err), 0);
    check(in_ready == '0, "R8 in_ready idle", 64'(in_ready), 0);

    // R2 and R1: child 1 -> child 3, one-cycle hop
    send(1, 2'd2, 2'd3);
    check(out_valid[3] == 1'b0, "R2 not early", 64'(out_valid[3]), 0);
    step();
    check(acc_m[1], "R2 accepted", 64'(acc_m), 64'h2);
    check(out_valid[3] && out_data[3] == expq[3][0], "R2 one-cycle hop", out_data[3], expq[3][0]);
    step();

    // R1: parent -> child 0, child 0 -> parent
    send(PARENT, 2'd2, 2'd0);
    send(0, 2'd3, 2'd1);
    step();
    check(out_valid[0] && out_valid[PARENT], "R1 down and up routes",
          64'(out_valid), 64'h11);
    step();

    // R7 protocol errors
    send(PARENT, 2'd0, 2'd1);
    step();
    check(acc_m[PARENT], "R7 bad packet consumed", 64'(acc_m), 64'h10);
    check(err && out_valid == '0, "R7 err and no forward", {63'(out_valid), err}, 64'h1);
    step();
    check(!err, "R7 err one cycle", 64'(err), 0);
    send(2, 2'd2, 2'd2);
    step();
    check(err && out_valid == '0, "R7 child u-turn", {63'(out_valid), err}, 64'h1);
    step();

    // R3 backpressure
    bready[PARENT] = 1'b0;
    send(0, 2'd1, 2'd0);
    step();
    send(1, 2'd0, 2'd2);
    begin
      logic [63:0] held;
      held = out_data[PARENT];
      for (int c = 0; c < 4; c++) begin
        check(out_valid[PARENT] && out_data[PARENT] == held, "R3 stall holds",
              out_data[PARENT], held);
        step();
        check(!acc_m[1], "R3 no accept while stalled", 64'(acc_m), 0);
      end
    end
    bready[PARENT] = 1'b1;
    step();
    check(acc_m[1], "R3 accept on release", 64'(acc_m), 64'h2);
    step();
    step();

    // R5 / R8 round-robin after reset
    do_reset();
    send(0, 2'd0, 2'd0);
    send(1, 2'd1, 2'd0);
    send(2, 2'd3, 2'd0);
    for (int c = 0; c < 6; c++) begin
      step();
      check(acc_m == 5'(1 << (c % 3)), "R5 round-robin order", 64'(acc_m), 64'(1 << (c % 3)));
      if (!bvalid[0]) send(0, 2'd0, 2'd0);
      if (!bvalid[1]) send(1, 2'd1, 2'd0);
      if (!bvalid[2]) send(2, 2'd3, 2'd0);
    end
    bvalid = '0;
    repeat (3) step();

    // random traffic with random backpressure
    for (int c = 0; c < 3000; c++) begin
      for (int i = 0; i < NP; i++) begin
        if (!bvalid[i] && ($urandom % 2) == 1) begin
          if (i == PARENT) send(i, 2'd2, 2'($urandom));
          else if (($urandom % 2) == 1) begin
            int p;
            p = $urandom % 3;
            send(i, (p == 2) ? 2'd3 : 2'(p), 2'($urandom));
          end else send(i, 2'd2, 2'((i + 1 + ($urandom % 3)) % 4));
        end
      end
      for (int o = 0; o < NP; o++) bready[o] = (($urandom % 4) != 0);
      step();
      if ((c % 100) == 0)
        check((rdy_s & ~val_s) == '0, "R4 ready only with valid", 64'(rdy_s), 64'(val_s));
    end

    // drain: nothing lost
    bvalid = '0;
    bready = '1;
    repeat (4) step();
    for (int o = 0; o < NP; o++)
      check(expn[o] == 0, "R6 all packets delivered", 64'(expn[o]), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule